// File: doc/BRIEF.md
# Stereo ADC Power-Down and Wake-Up Output Sequencer

This block sits between a stereo audio converter core and its serial output formatter. It runs on the master clock and decides when the converted left and right sample words may leave the block. While the active-low power-down pin is low, or while either external clock is missing, the block stays in a power-down state. In that state it holds both outputs at two's-complement zero and keeps the downstream decimation filter in reset.

Waking up needs three things: the pin must be high, the master-clock-present indication must be high, and the block must see a rising edge of the frame clock. That edge starts an initialization phase of a fixed number of frame periods, 4128 by default. Both channels stay at zero through that phase. When the phase ends, a status flag rises, and the samples pass through on every frame boundary, with the left and right words updating together.

The block leaves normal operation in three cases: the pin goes low, the master-clock indication drops, or the frame clock stops for longer than a watchdog window counted in master-clock cycles. In every case the frame count is lost, and the next wake-up starts the full initialization again.

Top module: `adc_pd_seq`

## Requirements
- R1: A low level on `pdn_n_i` forces both outputs to zero, drops `run_o` and raises `flt_rst_o` at once, without waiting for a clock edge; while in power-down, both outputs stay zero.
- R2: `flt_rst_o` is high in power-down and low during initialization and normal operation.
- R3: Leaving power-down requires all three of: `pdn_n_i` high after its two-flop synchronizer, `mck_ok_i` high, and a detected rising edge of `lrck_i`. Without any one of them the block stays in power-down.
- R4: `run_o` rises on the INIT_FRAMES-th (4128th) frame-clock rising edge after the edge that started initialization. It is still low at the edge before that one.
- R5: During initialization, `left_o` and `right_o` are both 16'h0000.
- R6: In normal operation, `left_o` and `right_o` load `left_i` and `right_i` together, once per frame-clock rising edge, and hold their values between edges. The first sample appears in the same cycle that `run_o` rises.
- R7: If `mck_ok_i` is low during initialization or normal operation, the block enters power-down on the next master-clock edge.
- R8: If no frame-clock rising edge arrives for WDOG_CYCLES master-clock cycles during initialization or normal operation, the block enters power-down.
- R9: Every entry to power-down clears the frame count. A wake-up after an aborted initialization again waits the full 4128 frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| pdn_n_i | input | 1 | Asynchronous active-low power-down pin |
| lrck_i | input | 1 | Frame clock, sampled in the master-clock domain |
| mck_ok_i | input | 1 | High while the master clock is known to be running |
| left_i | input | 16 | Left sample word from the converter core |
| right_i | input | 16 | Right sample word from the converter core |
| left_o | output | 16 | Gated left sample |
| right_o | output | 16 | Gated right sample |
| flt_rst_o | output | 1 | Reset to the downstream digital filter |
| run_o | output | 1 | High in normal operation |

## Verification
The assertions check on every cycle that:
- outputs are zero in power-down and initialization;
- the filter reset and the run flag never overlap;
- a wake-up always follows a frame edge with the master clock present;
- the run flag rises only as the frame count reaches its limit;
- outputs hold between frame edges;
- loss of the master clock or a silent watchdog window ends activity on the next edge.

Some behaviours need the bench's scenarios. These are: the exact frame at which the run flag rises, counted from the starting edge; the immediate effect of the pin between clock edges; the full recount after an aborted wake-up; and data matching the input words across corner values such as 16'h8000 and 16'h7FFF.

// File: rtl/adc_pd_pkg.sv
package adc_pd_pkg;
   typedef enum logic [1:0] {
      ST_PD   = 2'd0,
      ST_INIT = 2'd1,
      ST_RUN  = 2'd2
   } pd_state_e;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic pdn_n_i,
   input  logic lrck_i,
   output logic rst_n_o,
   output logic frame_edge_o
);
   // Power-down pin: clears at once, releases after STAGES clock edges.
   logic [STAGES-1:0] pd_q;
   logic [STAGES:0]   lr_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_i or negedge pdn_n_i) begin
            if (!pdn_n_i) pd_q <= '0;
            else          pd_q <= 1'b1;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge pdn_n_i) begin
            if (!pdn_n_i) pd_q <= '0;
            else          pd_q <= {pd_q[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   // Frame clock: synchronizer stages plus one stage for edge detection.
   always_ff @(posedge clk_i or negedge pdn_n_i) begin
      if (!pdn_n_i) lr_q <= '0;
      else          lr_q <= {lr_q[STAGES-1:0], lrck_i};
   end

   assign rst_n_o      = pd_q[STAGES-1];
   assign frame_edge_o = lr_q[STAGES-1] & ~lr_q[STAGES];
endmodule

// File: rtl/adc_frame_timer.sv
module adc_frame_timer
   import adc_pd_pkg::*;
#(
   parameter int INIT_FRAMES = 4128,
   parameter int CNT_W       = 13,
   parameter int WDOG_CYCLES = 64
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             frame_edge_i,
   input  logic             mck_ok_i,
   output pd_state_e        state_o,
   output logic             live_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int               WD_W    = $clog2(WDOG_CYCLES + 1);
   localparam logic [WD_W-1:0]  WD_MAX  = WD_W'(WDOG_CYCLES);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(INIT_FRAMES);

   pd_state_e        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [WD_W-1:0]  wd_q;
   logic             timeout;

   // Master-clock cycles since the last frame edge, saturating.
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)          wd_q <= '0;
      else if (frame_edge_i) wd_q <= '0;
      else if (wd_q != WD_MAX) wd_q <= wd_q + 1'b1;
   end

   assign timeout = (wd_q == WD_MAX);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_PD: begin
            cnt_d = '0;
            if (mck_ok_i && frame_edge_i) st_d = ST_INIT;
         end
         ST_INIT, ST_RUN: begin
            if (!mck_ok_i || timeout) begin
               st_d  = ST_PD;
               cnt_d = '0;
            end else if (st_q == ST_INIT && frame_edge_i) begin
               cnt_d = cnt_q + 1'b1;
               if (cnt_d == CNT_END) st_d = ST_RUN;
            end
         end
         default: begin
            st_d  = ST_PD;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         st_q  <= ST_PD;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;
   assign live_o  = (st_d == ST_RUN);
   assign cnt_o   = cnt_q;
endmodule

// File: rtl/adc_out_gate.sv
module adc_out_gate #(
   parameter int W   = 16,
   parameter int NCH = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_n_i,
   input  logic                  live_i,
   input  logic                  load_i,
   input  logic [NCH-1:0][W-1:0] samp_i,
   output logic [NCH-1:0][W-1:0] samp_o
);
   // One register per channel; all share the same load and clear.
   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i)    samp_o[ch] <= '0;
            else if (!live_i) samp_o[ch] <= '0;
            else if (load_i)  samp_o[ch] <= samp_i[ch];
         end
      end
   endgenerate
endmodule

// File: rtl/adc_pd_seq.sv
module adc_pd_seq
   import adc_pd_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int INIT_FRAMES = 4128,
   parameter int CNT_W       = 13,
   parameter int WDOG_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                pdn_n_i,
   input  logic                lrck_i,
   input  logic                mck_ok_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                flt_rst_o,
   output logic                run_o
);
   localparam int NCH = 2;

   generate
      if (INIT_FRAMES < 2 || INIT_FRAMES >= (1 << CNT_W)) begin : g_bad_cnt
         $error("INIT_FRAMES must fit in CNT_W bits and be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (WDOG_CYCLES < 4) begin : g_bad_wdog
         $error("WDOG_CYCLES must be at least 4");
      end
   endgenerate

   logic                          rst_n;
   logic                          frame_edge;
   logic                          live;
   pd_state_e                     st_q;
   logic [CNT_W-1:0]              cnt_q;
   logic [NCH-1:0][SAMPLE_W-1:0]  samp_in, samp_out;

   adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i        (clk_i),
      .pdn_n_i      (pdn_n_i),
      .lrck_i       (lrck_i),
      .rst_n_o      (rst_n),
      .frame_edge_o (frame_edge)
   );

   adc_frame_timer #(
      .INIT_FRAMES (INIT_FRAMES),
      .CNT_W       (CNT_W),
      .WDOG_CYCLES (WDOG_CYCLES)
   ) u_timer (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n),
      .frame_edge_i (frame_edge),
      .mck_ok_i     (mck_ok_i),
      .state_o      (st_q),
      .live_o       (live),
      .cnt_o        (cnt_q)
   );

   assign samp_in = {left_i, right_i};

   adc_out_gate #(.W(SAMPLE_W), .NCH(NCH)) u_gate (
      .clk_i   (clk_i),
      .rst_n_i (rst_n),
      .live_i  (live),
      .load_i  (frame_edge),
      .samp_i  (samp_in),
      .samp_o  (samp_out)
   );

   assign left_o    = samp_out[1];
   assign right_o   = samp_out[0];
   assign flt_rst_o = (st_q == ST_PD);
   assign run_o     = (st_q == ST_RUN);
endmodule

// File: rtl/adc_pd_seq_chk.sv
module adc_pd_seq_chk
   import adc_pd_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int INIT_FRAMES = 4128,
   parameter int CNT_W       = 13,
   parameter int WDOG_CYCLES = 64
) (
   input logic                clk_i,
   input logic                rst_n_i,
   input logic                mck_ok_i,
   input logic                edge_i,
   input logic [1:0]          st_i,
   input logic [CNT_W-1:0]    cnt_i,
   input logic                run_i,
   input logic                flt_i,
   input logic [SAMPLE_W-1:0] left_i,
   input logic [SAMPLE_W-1:0] right_i
);
   localparam int              SIL_W   = $clog2(WDOG_CYCLES + 2);
   localparam logic [SIL_W-1:0] SIL_LIM = SIL_W'(WDOG_CYCLES);
   localparam logic [SIL_W-1:0] SIL_TOP = SIL_W'(WDOG_CYCLES + 1);

   logic [SIL_W-1:0] silent_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)              silent_q <= '0;
      else if (edge_i)           silent_q <= '0;
      else if (silent_q != SIL_TOP) silent_q <= silent_q + 1'b1;
   end

   AST_PD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (st_i == ST_PD) |-> (left_i == '0 && right_i == '0)); // R1

   AST_RST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      run_i |-> !flt_i); // R2

   AST_WAKE_COND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($past(st_i) == ST_PD && st_i == ST_INIT) |-> $past(edge_i && mck_ok_i)); // R3

   AST_RUN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(run_i) |-> (cnt_i == CNT_W'(INIT_FRAMES) &&
                        $past(cnt_i) == CNT_W'(INIT_FRAMES - 1) &&
                        $past(st_i) == ST_INIT)); // R4

   AST_INIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (st_i == ST_INIT) |-> (left_i == '0 && right_i == '0)); // R5

   AST_HOLD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (run_i && $past(run_i) && !$past(edge_i)) |-> ($stable(left_i) && $stable(right_i))); // R6

   AST_MCK_LOSS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (st_i != ST_PD && !mck_ok_i) |=> (st_i == ST_PD)); // R7

   AST_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (st_i != ST_PD && silent_q >= SIL_LIM) |=> (st_i == ST_PD)); // R8
endmodule

bind adc_pd_seq adc_pd_seq_chk #(
   .SAMPLE_W    (SAMPLE_W),
   .INIT_FRAMES (INIT_FRAMES),
   .CNT_W       (CNT_W),
   .WDOG_CYCLES (WDOG_CYCLES)
) u_chk (
   .clk_i    (clk_i),
   .rst_n_i  (rst_n),
   .mck_ok_i (mck_ok_i),
   .edge_i   (frame_edge),
   .st_i     (st_q),
   .cnt_i    (cnt_q),
   .run_i    (run_o),
   .flt_i    (flt_rst_o),
   .left_i   (left_o),
   .right_i  (right_o)
);

// File: tb/test_adc_pd_seq.sv
module test_adc_pd_seq;
   localparam int CLK_PERIOD = 10;
   localparam int INIT_FR    = 4128;
   localparam int WDOG       = 64;
   localparam int MAX_CYC    = 190000;

   logic        clk = 1'b0;
   logic        pdn_n, lrck, mck_ok;
   logic [15:0] l_in, r_in;
   logic [15:0] l_out, r_out;
   logic        flt_rst, run;
   int          errs = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_pd_seq i_adc_pd_seq (
      .clk_i     (clk),
      .pdn_n_i   (pdn_n),
      .lrck_i    (lrck),
      .mck_ok_i  (mck_ok),
      .left_i    (l_in),
      .right_i   (r_in),
      .left_o    (l_out),
      .right_o   (r_out),
      .flt_rst_o (flt_rst),
      .run_o     (run)
   );

   // Expected {run, left, right} for a frame check.
   function automatic logic [32:0] exp_word(input bit running, input logic [15:0] l, input logic [15:0] r);
      return running ? {1'b1, l, r} : {1'b0, 16'h0000, 16'h0000};
   endfunction

   function automatic logic [15:0] pick_word();
      case ($urandom_range(0, 5))
         0: return 16'h8000;
         1: return 16'h7FFF;
         2: return 16'hFFFF;
         3: return 16'h0001;
         default: return 16'($urandom);
      endcase
   endfunction

   task automatic check(input logic [32:0] act, input logic [32:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One frame: 4 cycles high, 4 low. mode 0 expects zeros, 1 expects data, 2 no check.
   task automatic do_frame(input int mode, input string req);
      logic [15:0] pl, pr;
      @(negedge clk) lrck = 1'b1;
      repeat (4) @(negedge clk);
      if (mode != 2) check({run, l_out, r_out}, exp_word(mode == 1, l_in, r_in), req);
      lrck = 1'b0;
      pl = l_in;
      pr = r_in;
      l_in = pick_word();
      r_in = pick_word();
      repeat (2) @(negedge clk);
      if (mode == 1) check({run, l_out, r_out}, {1'b1, pl, pr}, "R6 hold");
      @(negedge clk);
   endtask

   // Frames counted from the starting edge k=0; run expected from k=INIT_FR.
   task automatic wake_run(input int nfr, input string req);
      for (int k = 0; k < nfr; k++) begin
         int  mode;
         bit  sel;
         sel  = (k == 0) || (k == INIT_FR - 1) || (k >= INIT_FR) || (k % 700 == 0);
         mode = sel ? ((k >= INIT_FR) ? 1 : 0) : 2;
         if (k == INIT_FR - 1 || k == INIT_FR) do_frame(mode, req);
         else if (k >= INIT_FR)                do_frame(mode, "R6");
         else                                  do_frame(mode, "R5");
         if (k == 0) check({32'd0, flt_rst}, 33'd0, "R2 init");
      end
   endtask

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'hA5C3));
      pdn_n = 1'b0; lrck = 1'b0; mck_ok = 1'b1;
      l_in = pick_word(); r_in = pick_word();
      repeat (5) @(negedge clk);
      check({run, l_out, r_out}, 33'd0, "R1 reset");
      check({32'd0, flt_rst}, 33'd1, "R2 reset");

      // R3: pin high but master clock absent
      mck_ok = 1'b0; pdn_n = 1'b1;
      for (int i = 0; i < 3; i++) do_frame(0, "R3 no mclk");
      check({32'd0, flt_rst}, 33'd1, "R3 no mclk");
      // R3: master clock present, pin low
      mck_ok = 1'b1; pdn_n = 1'b0;
      for (int i = 0; i < 3; i++) do_frame(0, "R3 pin low");
      check({32'd0, flt_rst}, 33'd1, "R3 pin low");
      // R3: pin high, clock present, but no frame edge
      pdn_n = 1'b1;
      repeat (30) @(negedge clk);
      check({32'd0, flt_rst}, 33'd1, "R3 no frame edge");

      // Wake 1: full count
      wake_run(INIT_FR + 6, "R4");

      // R1: pin low between clock edges takes effect at once
      @(negedge clk);
      #(CLK_PERIOD / 4) pdn_n = 1'b0;
      #1;
      check({run, l_out, r_out}, 33'd0, "R1 async");
      check({32'd0, flt_rst}, 33'd1, "R1 async flt");
      repeat (4) @(negedge clk);

      // Wake 2 aborted mid-initialization, then wake 3 must recount fully
      pdn_n = 1'b1;
      wake_run(2000, "R5");
      @(negedge clk) pdn_n = 1'b0;
      repeat (3) @(negedge clk);
      check({run, l_out, r_out}, 33'd0, "R1 abort");
      pdn_n = 1'b1;
      wake_run(INIT_FR + 4, "R9");

      // R8: frame clock stops while running
      repeat (WDOG + 20) @(negedge clk);
      check({run, l_out, r_out}, 33'd0, "R8 silence");
      check({32'd0, flt_rst}, 33'd1, "R8 filter reset");

      // Wake 4 after the silence, then master-clock loss
      wake_run(INIT_FR + 3, "R4 rewake");
      @(negedge clk) mck_ok = 1'b0;
      repeat (2) @(negedge clk);
      check({run, l_out, r_out}, 33'd0, "R7 mclk loss");
      check({32'd0, flt_rst}, 33'd1, "R7 filter reset");
      mck_ok = 1'b1;
      for (int i = 0; i < 4; i++) do_frame(0, "R7 recount");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule